// File: doc/BRIEF.md
# Multichannel Scan Result Buffer with Clock-Stretch Readback

This block sits between the slave side of a two-wire serial interface and a four-channel, 10-bit converter. Once the bus logic reports that the device address matched, the block arms itself. On the falling edge of the ninth clock it captures the channel and mode settings. It then asks the converter for one result per scanned channel, from channel 0 upward, back to back. While the scan runs it holds the serial clock low. It lets the clock go only after the final result of the scan has been stored.

Each raw signed difference from the converter is shaped into a 10-bit code before it is stored. Single-ended and unipolar modes give straight binary, and bipolar mode gives two's complement. The bus logic then pulls the results out one byte at a time, in the order they were converted. Reading past the last result wraps back to the first one. Starting a new scan throws away every earlier result.

Top module: `scan_readback`

## Requirements
- R1: After reset, hold_scl_o and conv_req_o are low and rd_data_o reads 8'hFC, which is the high byte of an all-zero result.
- R2: An ack_fall_i pulse that follows an addr_hit_i pulse raises hold_scl_o and conv_req_o one cycle later, with conv_ch_o = 0. The chan_sel_i, single_end_i, bipolar_i and ref_pin_i values present in that cycle are captured for the whole scan.
- R3: An ack_fall_i pulse with no addr_hit_i since the last scan (or since reset) is ignored, and hold_scl_o stays low.
- R4: Channels are requested in ascending order from 0 up to the last scanned channel. conv_ch_o steps by one on each conv_done_i pulse, and conv_req_o stays high throughout. hold_scl_o stays high until the cycle after the conv_done_i of the last channel.
- R5: The last scanned channel is chan_sel_i, clamped to 3 when ref_pin_i = 0 and to 2 when ref_pin_i = 1. Channel 3 is never requested while its pin serves as reference.
- R6: Each result r is read as two bytes: first {6'b111111, r[9:8]}, then r[7:0]. A rd_byte_i pulse moves from the high byte to the low byte. A pulse on the low byte moves to the next result, in conversion order.
- R7: A rd_byte_i pulse on the low byte of the last stored result returns the read position to the high byte of the first result.
- R8: A new scan resets the read position to the high byte of result 0 and replaces all stored results.
- R9: With single_end_i = 1, the code is the difference clamped to 0..1023 as straight binary, whatever the value of bipolar_i.
- R10: With single_end_i = 0 and bipolar_i = 0, a negative difference gives code 0, and a positive one gives straight binary.
- R11: With single_end_i = 0 and bipolar_i = 1, the difference is clamped to -512..511 and stored as 10-bit two's complement.
- R12: rd_byte_i pulses while hold_scl_o is high leave the read position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_hit_i | input | 1 | Pulse: valid address seen on eighth rising bus clock |
| ack_fall_i | input | 1 | Pulse: falling edge of ninth bus clock |
| chan_sel_i | input | 2 | Highest channel requested for the scan |
| single_end_i | input | 1 | 1 = single-ended input mode |
| bipolar_i | input | 1 | 1 = bipolar coding in differential mode |
| ref_pin_i | input | 1 | 1 = channel 3 pin used as reference |
| conv_req_o | output | 1 | Conversion request, level |
| conv_ch_o | output | 2 | Channel to convert |
| conv_done_i | input | 1 | Pulse: conversion finished, difference valid |
| conv_diff_i | input | 11 | Signed raw difference, unipolar LSB units |
| hold_scl_o | output | 1 | 1 = drive serial clock low |
| rd_byte_i | input | 1 | Pulse: current byte consumed by bus logic |
| rd_data_o | output | 8 | Byte presented for reading |

## Verification
hold_scl_o and the first request rise one cycle after ack_fall_i. Each conv_done_i moves conv_ch_o on the next cycle. The done pulse of the last channel drops hold_scl_o on the next cycle. rd_data_o shows the new byte one cycle after a rd_byte_i pulse. The bench drives every input on the falling clock edge and samples at the next falling edge, so each check lands exactly one register stage after its stimulus. Expected channel sequences, byte values and wrap points come from the clamping and ordering rules, with no reference to the design's internal state.

// File: rtl/scan_pkg.sv
package scan_pkg;
  parameter int NUM_CH = 4;
  parameter int RES_W  = 10;
  parameter int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRACK = 2'd1,
    ST_CONV  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/code_fmt.sv
module code_fmt #(
  parameter int RES_W = scan_pkg::RES_W,
  localparam int DIFF_W = RES_W + 1
) (
  input  logic signed [DIFF_W-1:0] diff_i,
  input  logic                     single_end_i,
  input  logic                     bipolar_i,
  output logic [RES_W-1:0]         code_o
);
  localparam logic signed [DIFF_W-1:0] BIP_MAX = DIFF_W'((1 << (RES_W-1)) - 1);
  localparam logic signed [DIFF_W-1:0] BIP_MIN = -DIFF_W'(1 << (RES_W-1));

  always_comb begin
    if (single_end_i || !bipolar_i) begin
      code_o = diff_i[DIFF_W-1] ? '0 : diff_i[RES_W-1:0];
    end else if (diff_i > BIP_MAX) begin
      code_o = BIP_MAX[RES_W-1:0];
    end else if (diff_i < BIP_MIN) begin
      code_o = BIP_MIN[RES_W-1:0];
    end else begin
      code_o = diff_i[RES_W-1:0];
    end
  end
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_pkg::*;
#(
  parameter int NUM_CH = scan_pkg::NUM_CH,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            addr_hit_i,
  input  logic            ack_fall_i,
  input  logic [CH_W-1:0] chan_sel_i,
  input  logic            single_end_i,
  input  logic            bipolar_i,
  input  logic            ref_pin_i,
  input  logic            conv_done_i,
  output logic            conv_req_o,
  output logic [CH_W-1:0] conv_ch_o,
  output logic            busy_o,
  output logic            clr_o,
  output logic            wr_en_o,
  output logic [CH_W-1:0] wr_idx_o,
  output logic            se_o,
  output logic            bip_o,
  output logic            ref_o
);
  seq_st_e         st_q;
  logic [CH_W-1:0] ch_q, last_q, lim, last_d;
  logic            se_q, bip_q, ref_q;

  // top pin lost to the reference lowers the scan ceiling by one
  always_comb begin
    lim    = ref_pin_i ? CH_W'(NUM_CH - 2) : CH_W'(NUM_CH - 1);
    last_d = (chan_sel_i > lim) ? lim : chan_sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ch_q   <= '0;
      last_q <= '0;
      se_q   <= 1'b0;
      bip_q  <= 1'b0;
      ref_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (addr_hit_i) st_q <= ST_TRACK;
        ST_TRACK: if (ack_fall_i) begin
          st_q   <= ST_CONV;
          ch_q   <= '0;
          last_q <= last_d;
          se_q   <= single_end_i;
          bip_q  <= bipolar_i;
          ref_q  <= ref_pin_i;
        end
        ST_CONV: if (conv_done_i) begin
          if (ch_q == last_q) st_q <= ST_IDLE;
          else                ch_q <= ch_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign conv_req_o = (st_q == ST_CONV);
  assign conv_ch_o  = ch_q;
  assign busy_o     = (st_q == ST_CONV);
  assign clr_o      = (st_q == ST_TRACK) && ack_fall_i;
  assign wr_en_o    = (st_q == ST_CONV) && conv_done_i;
  assign wr_idx_o   = ch_q;
  assign se_o       = se_q;
  assign bip_o      = bip_q;
  assign ref_o      = ref_q;
endmodule

// File: rtl/result_store.sv
module result_store #(
  parameter int NUM_CH = scan_pkg::NUM_CH,
  parameter int RES_W  = scan_pkg::RES_W,
  parameter int BYTE_W = scan_pkg::BYTE_W,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int CNT_W = $clog2(NUM_CH + 1),
  localparam int PAD_W = 2*BYTE_W - RES_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_idx_i,
  input  logic [RES_W-1:0]  wr_data_i,
  input  logic              busy_i,
  input  logic              rd_byte_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic [NUM_CH*RES_W-1:0] slot_flat;
  logic [CNT_W-1:0]        cnt_q;
  logic [CH_W-1:0]         ptr_q;
  logic                    lo_q;
  logic [RES_W-1:0]        cur;
  logic                    at_end;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic [RES_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 q <= '0;
      else if (wr_en_i && wr_idx_i == CH_W'(g))    q <= wr_data_i;
    end
    assign slot_flat[g*RES_W +: RES_W] = q;
  end

  assign cur    = slot_flat[ptr_q*RES_W +: RES_W];
  assign at_end = (CNT_W'(ptr_q) + 1'b1) >= cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ptr_q <= '0;
      lo_q  <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ptr_q <= '0;
      lo_q  <= 1'b0;
    end else begin
      if (wr_en_i) cnt_q <= CNT_W'(wr_idx_i) + 1'b1;
      if (rd_byte_i && !busy_i) begin
        lo_q <= !lo_q;
        if (lo_q) ptr_q <= at_end ? '0 : ptr_q + 1'b1;
      end
    end
  end

  assign rd_data_o = lo_q ? cur[BYTE_W-1:0] : {{PAD_W{1'b1}}, cur[RES_W-1:BYTE_W]};
endmodule

// File: rtl/scan_readback.sv
module scan_readback #(
  parameter int NUM_CH = scan_pkg::NUM_CH,
  parameter int RES_W  = scan_pkg::RES_W,
  parameter int BYTE_W = scan_pkg::BYTE_W,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int DIFF_W = RES_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     addr_hit_i,
  input  logic                     ack_fall_i,
  input  logic [CH_W-1:0]          chan_sel_i,
  input  logic                     single_end_i,
  input  logic                     bipolar_i,
  input  logic                     ref_pin_i,
  output logic                     conv_req_o,
  output logic [CH_W-1:0]          conv_ch_o,
  input  logic                     conv_done_i,
  input  logic signed [DIFF_W-1:0] conv_diff_i,
  output logic                     hold_scl_o,
  input  logic                     rd_byte_i,
  output logic [BYTE_W-1:0]        rd_data_o
);
  logic            busy, clr, wr_en, se_lat, bip_lat, ref_lat;
  logic [CH_W-1:0] wr_idx;
  logic [RES_W-1:0] code;

  scan_seq #(.NUM_CH(NUM_CH)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .addr_hit_i(addr_hit_i), .ack_fall_i(ack_fall_i),
    .chan_sel_i(chan_sel_i), .single_end_i(single_end_i),
    .bipolar_i(bipolar_i), .ref_pin_i(ref_pin_i),
    .conv_done_i(conv_done_i),
    .conv_req_o(conv_req_o), .conv_ch_o(conv_ch_o),
    .busy_o(busy), .clr_o(clr), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .se_o(se_lat), .bip_o(bip_lat), .ref_o(ref_lat)
  );

  code_fmt #(.RES_W(RES_W)) u_fmt (
    .diff_i(conv_diff_i), .single_end_i(se_lat),
    .bipolar_i(bip_lat), .code_o(code)
  );

  result_store #(.NUM_CH(NUM_CH), .RES_W(RES_W), .BYTE_W(BYTE_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(code),
    .busy_i(busy), .rd_byte_i(rd_byte_i), .rd_data_o(rd_data_o)
  );

  assign hold_scl_o = busy;
endmodule

// File: rtl/scan_readback_chk.sv
module scan_readback_chk #(
  parameter int NUM_CH = scan_pkg::NUM_CH,
  parameter int BYTE_W = scan_pkg::BYTE_W,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_fall_i,
  input logic              conv_req_o,
  input logic [CH_W-1:0]   conv_ch_o,
  input logic              conv_done_i,
  input logic              hold_scl_o,
  input logic              rd_byte_i,
  input logic [BYTE_W-1:0] rd_data_o,
  input logic              ref_lat
);
  AST_HOLD_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_scl_o) |-> $past(ack_fall_i)); // R2

  AST_FIRST_CH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_req_o) |-> conv_ch_o == '0); // R4

  AST_CH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_req_o && conv_done_i) |=> (!conv_req_o || conv_ch_o == $past(conv_ch_o) + 1'b1)); // R4

  AST_REF_EXCLUDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_req_o && ref_lat) |-> conv_ch_o != CH_W'(NUM_CH - 1)); // R5

  AST_RD_IGNORED_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_scl_o && rd_byte_i && !conv_done_i) |=> $stable(rd_data_o)); // R12
endmodule

bind scan_readback scan_readback_chk #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_fall_i(ack_fall_i),
  .conv_req_o(conv_req_o), .conv_ch_o(conv_ch_o), .conv_done_i(conv_done_i),
  .hold_scl_o(hold_scl_o), .rd_byte_i(rd_byte_i), .rd_data_o(rd_data_o),
  .ref_lat(ref_lat)
);

// File: tb/scan_readback_bench.sv
module scan_readback_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic addr_hit_i = 0, ack_fall_i = 0, single_end_i = 0, bipolar_i = 0, ref_pin_i = 0;
  logic [1:0] chan_sel_i = 0;
  logic conv_req_o, conv_done_i = 0, hold_scl_o, rd_byte_i = 0;
  logic [1:0] conv_ch_o;
  logic signed [10:0] conv_diff_i = 0;
  logic [7:0] rd_data_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [9:0] exp_code [4];

  // {sel, se, bip, ref, d0, d1, d2, d3}
  localparam logic [48:0] VEC [NVEC] = '{
    {2'd3, 1'b1, 1'b0, 1'b0, 11'sd5,    -11'sd7,   11'sd1023, 11'sd600},
    {2'd3, 1'b1, 1'b1, 1'b1, 11'sd300,  11'sd2,    11'sd777,  11'sd44},
    {2'd2, 1'b0, 1'b0, 1'b0, 11'sd40,   -11'sd300, 11'sd1000, 11'sd9},
    {2'd3, 1'b0, 1'b1, 1'b0, -11'sd600, 11'sd700,  -11'sd3,   11'sd100},
    {2'd0, 1'b1, 1'b0, 1'b0, 11'sd513,  11'sd1,    11'sd2,    11'sd3},
    {2'd1, 1'b0, 1'b1, 1'b1, 11'sd9,    -11'sd1,   11'sd8,    11'sd7}
  };

  scan_readback u_scan_readback (
    .clk_i(clk), .rst_ni(rst_ni), .addr_hit_i(addr_hit_i), .ack_fall_i(ack_fall_i),
    .chan_sel_i(chan_sel_i), .single_end_i(single_end_i), .bipolar_i(bipolar_i),
    .ref_pin_i(ref_pin_i), .conv_req_o(conv_req_o), .conv_ch_o(conv_ch_o),
    .conv_done_i(conv_done_i), .conv_diff_i(conv_diff_i), .hold_scl_o(hold_scl_o),
    .rd_byte_i(rd_byte_i), .rd_data_o(rd_data_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] f_code(logic signed [10:0] d, logic se, logic bip);
    if (se || !bip) return d < 0 ? 10'd0 : d[9:0];
    if (d > 11'sd511) return 10'h1FF;
    if (d < -11'sd512) return 10'h200;
    return d[9:0];
  endfunction

  // returns number of results stored
  task automatic run_scan(input logic [48:0] v, input bit poke, output int n);
    logic [1:0] sel = v[48:47];
    logic se = v[46], bip = v[45], rf = v[44];
    logic signed [10:0] d [4];
    int last;
    d[0] = v[43:33]; d[1] = v[32:22]; d[2] = v[21:11]; d[3] = v[10:0];
    last = int'(sel);
    if (rf && last > 2) last = 2;
    if (!rf && last > 3) last = 3;
    n = last + 1;
    @(negedge clk);
    chan_sel_i = sel; single_end_i = se; bipolar_i = bip; ref_pin_i = rf; addr_hit_i = 1;
    @(negedge clk);
    addr_hit_i = 0; ack_fall_i = 1;
    @(negedge clk);
    ack_fall_i = 0;
    chan_sel_i = ~sel; single_end_i = ~se; bipolar_i = ~bip; ref_pin_i = ~rf;
    chk(hold_scl_o && conv_req_o && conv_ch_o == 0, "R2 start",
        {hold_scl_o, conv_req_o, conv_ch_o}, 4'b1100);
    for (int k = 0; k <= last; k++) begin
      rd_byte_i = poke;
      @(negedge clk);
      rd_byte_i = 0;
      @(negedge clk);
      chk(conv_req_o && hold_scl_o && conv_ch_o == 2'(k), rf ? "R5 channel" : "R4 channel",
          {conv_req_o, hold_scl_o, conv_ch_o}, {2'b11, 2'(k)});
      conv_done_i = 1; conv_diff_i = d[k];
      exp_code[k] = f_code(d[k], se, bip);
      @(negedge clk);
      conv_done_i = 0;
      if (k == last) chk(!hold_scl_o && !conv_req_o, "R4 release", hold_scl_o, 0);
      else           chk(hold_scl_o, "R4 hold", hold_scl_o, 1);
    end
  endtask

  task automatic pulse_rd();
    rd_byte_i = 1;
    @(negedge clk);
    rd_byte_i = 0;
  endtask

  task automatic read_all(input int n, input string mtag);
    for (int j = 0; j < 2*(n+1); j++) begin
      int idx = (j/2) % n;
      logic [7:0] e = (j % 2 == 0) ? {6'h3F, exp_code[idx][9:8]} : exp_code[idx][7:0];
      string tag = (j/2 >= n) ? "R7 wrap" : ((j % 2 == 0) ? "R6 high byte" : mtag);
      chk(rd_data_o == e, tag, rd_data_o, e);
      pulse_rd();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    wrap_up();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(!hold_scl_o && !conv_req_o && rd_data_o == 8'hFC, "R1 reset", rd_data_o, 8'hFC);
    rst_ni = 1;
    @(negedge clk);
    chk(!hold_scl_o && rd_data_o == 8'hFC, "R1 after reset", rd_data_o, 8'hFC);

    // R3: ninth edge with no address match
    ack_fall_i = 1;
    @(negedge clk);
    ack_fall_i = 0;
    @(negedge clk);
    chk(!hold_scl_o && !conv_req_o, "R3 no address", hold_scl_o, 0);

    for (int i = 0; i < NVEC; i++) begin
      string mt = VEC[i][46] ? "R9 single-ended" : (VEC[i][45] ? "R11 bipolar" : "R10 unipolar");
      run_scan(VEC[i], 1'b0, n);
      read_all(n, mt);
    end

    // R12: reads during the scan are ignored
    run_scan(VEC[0], 1'b1, n);
    chk(rd_data_o == {6'h3F, exp_code[0][9:8]}, "R12 held reads",
        rd_data_o, {6'h3F, exp_code[0][9:8]});
    read_all(n, "R9 single-ended");

    // R8: new scan mid-read restarts at result 0 with new data
    run_scan(VEC[3], 1'b0, n);
    pulse_rd();
    pulse_rd();
    pulse_rd();
    run_scan(VEC[2], 1'b0, n);
    chk(rd_data_o == {6'h3F, exp_code[0][9:8]}, "R8 restart",
        rd_data_o, {6'h3F, exp_code[0][9:8]});
    pulse_rd();
    chk(rd_data_o == exp_code[0][7:0], "R8 replaced", rd_data_o, exp_code[0][7:0]);
    wrap_up();
  end
endmodule